// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream. On a rising clock edge it either captures the whole parallel word at once or moves every bit one place toward the top stage, taking a new bit from a serial input into the bottom stage. An active-low clock enable holds the register still. An active-low clear empties the register immediately and needs no clock edge.

Only the top stage leaves the block. Connecting that output to the serial input of a second instance gives a longer converter. The word width is a parameter, and its default is eight bits. The clock enable works as a synchronous qualifier on one free-running clock. No clock is gated. All data and control pins are plain level signals with no handshake. The register moves only when the enable is low, so a consumer that is not ready can stall the stream by driving the enable high.

Top module: `pso_shifter`

## Requirements
- R1: With `en_n` low and `load_n` low at a rising edge of `clk`, the register takes `par_in`. Bit i of `par_in` goes to stage i. After the edge, `ser_out` equals `par_in[WIDTH-1]`.
- R2: With `en_n` low and `load_n` high at a rising edge, stage 0 takes `ser_in` and stage i takes the old value of stage i-1. After the edge, `ser_out` equals the old stage WIDTH-2.
- R3: With `en_n` high at a rising edge, every stage keeps its value for any level of `load_n`, `ser_in` and `par_in`. A later shift then continues the stream from where it stopped.
- R4: When `clr_n` goes low, every stage becomes 0 at once, with no clock edge needed. `ser_out` is 0 until the next load or shift after `clr_n` returns high.
- R5: While `clr_n` is low, rising edges change nothing, even with `en_n` low, `load_n` low and `par_in` all ones.
- R6: `ser_out` is the top stage (WIDTH-1). When one instance's `ser_out` drives the next instance's `ser_in`, the pair acts as one 2*WIDTH shifter. The downstream word leaves first, highest bit first, and the upstream word follows.
- R7: During a parallel load, `ser_in` has no effect. Stage 0 gets `par_in[0]` whatever level `ser_in` has.
- R8: After reset with `clr_n` low, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock. State changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| en_n | input | 1 | Clock enable, active low. When high, the register holds |
| load_n | input | 1 | Parallel load select, active low. When high, the register shifts |
| ser_in | input | 1 | Serial data input into stage 0 |
| par_in | input | WIDTH | Parallel word. Bit i goes to stage i |
| ser_out | output | 1 | Top stage (WIDTH-1), the serial output |

## Verification
Two instances are chained into a 16-bit converter. The bench loads 256 word pairs whose upper byte runs through every value and whose lower byte is derived from it arithmetically. Each pair is then shifted out in full, which checks both the load mapping and the order in which the two words leave the chain. A separate pass fills the chain through the serial input alone, so bits from the serial path can be told apart from bits that were loaded. A hold window in the middle of a stream toggles every other input to show that the enable freezes the register. A clear in mid-stream, followed by a clocked load attempt while the clear is still low, separates the asynchronous clear from a synchronous one.

// File: rtl/pso_pkg.sv
`timescale 1ns/1ps
package pso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } pso_op_e;
endpackage

// File: rtl/pso_ctrl.sv
`timescale 1ns/1ps
// Decodes the enable and load-select pins into one operation.
// Priority: hold, then load, then shift.
module pso_ctrl
  import pso_pkg::*;
(
  input  logic    en_n,
  input  logic    load_n,
  output pso_op_e op
);
  always_comb begin
    if (en_n)        op = OP_HOLD;
    else if (!load_n) op = OP_LOAD;
    else             op = OP_SHIFT;
  end
endmodule

// File: rtl/pso_cell.sv
`timescale 1ns/1ps
// One storage stage with an asynchronous clear.
module pso_cell
  import pso_pkg::*;
(
  input  logic    clk,
  input  logic    clr_n,
  input  pso_op_e op,
  input  logic    par_d,
  input  logic    link_d,
  output logic    q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= 1'b0;
    end else begin
      case (op)
        OP_LOAD:  q <= par_d;
        OP_SHIFT: q <= link_d;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pso_shifter.sv
`timescale 1ns/1ps
module pso_shifter
  import pso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             en_n,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int TOP = WIDTH - 1;

  pso_op_e          op;
  logic [WIDTH-1:0] stages;

  pso_ctrl u_ctrl (
    .en_n   (en_n),
    .load_n (load_n),
    .op     (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic link;
    if (i == 0) begin : g_head
      assign link = ser_in;
    end else begin : g_body
      assign link = stages[i-1];
    end
    pso_cell u_cell (
      .clk    (clk),
      .clr_n  (clr_n),
      .op     (op),
      .par_d  (par_in[i]),
      .link_d (link),
      .q      (stages[i])
    );
  end

  assign ser_out = stages[TOP];

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_n && !load_n) |=> (stages == $past(par_in)));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_n && load_n) |=> (stages == {$past(stages[TOP-1:0]), $past(ser_in)}));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
    en_n |=> $stable(stages));

  // R4
  clear_zero_chk: assert property (@(posedge clk)
    !clr_n |-> (stages == '0));

  // R6
  out_top_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_n && load_n) |=> (ser_out == $past(stages[TOP-1])));
endmodule

// File: tb/sim_pso_shifter.sv
`timescale 1ns/1ps
module sim_pso_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n, en_n, load_n, ser_in;
  logic [W-1:0] par_hi, par_lo;
  logic         link, chain_out;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  // u0 is upstream and carries the low word. u1 is downstream and drives the chain output.
  pso_shifter #(.WIDTH(W)) u0 (
    .clk(clk), .clr_n(clr_n), .en_n(en_n), .load_n(load_n),
    .ser_in(ser_in), .par_in(par_lo), .ser_out(link));
  pso_shifter #(.WIDTH(W)) u1 (
    .clk(clk), .clr_n(clr_n), .en_n(en_n), .load_n(load_n),
    .ser_in(link), .par_in(par_hi), .ser_out(chain_out));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    logic [15:0] word;
    logic [15:0] s;
    clr_n = 1'b0; en_n = 1'b1; load_n = 1'b1; ser_in = 1'b0;
    par_hi = '0; par_lo = '0;
    #12;
    chk("R8", chain_out, 1'b0);
    clr_n = 1'b1;
    tick();

    // Load sweep. ser_in is high during each load to show it is ignored.
    for (int v = 0; v < 256; v++) begin
      par_hi = v[7:0];
      par_lo = 8'((v * 37 + 11) & 8'hFF);
      word = {par_hi, par_lo};
      en_n = 1'b0; load_n = 1'b0; ser_in = 1'b1;
      tick();
      load_n = 1'b1; ser_in = 1'b0;
      chk("R1", chain_out, word[15]);
      for (int k = 1; k < 16; k++) begin
        tick();
        if (k == 15) chk("R7", chain_out, word[0]);
        else chk("R6", chain_out, word[15-k]);
      end
    end

    // Hold window in mid-stream
    word = 16'hA5C3;
    par_hi = word[15:8]; par_lo = word[7:0];
    load_n = 1'b0; tick(); load_n = 1'b1;
    for (int k = 1; k <= 4; k++) tick();
    chk("R2", chain_out, word[11]);
    en_n = 1'b1;
    for (int j = 0; j < 6; j++) begin
      load_n = j[0]; ser_in = ~j[0];
      par_hi = 8'(j * 53); par_lo = 8'(j * 91 + 7);
      tick();
      chk("R3", chain_out, word[11]);
    end
    en_n = 1'b0; load_n = 1'b1; ser_in = 1'b0;
    for (int k = 5; k < 16; k++) begin
      tick();
      chk("R3", chain_out, word[15-k]);
    end

    // Fill the chain through the serial input only
    s = 16'hB38D;
    for (int j = 0; j < 16; j++) begin
      ser_in = s[15-j];
      tick();
    end
    ser_in = 1'b0;
    chk("R2", chain_out, s[15]);
    for (int k = 1; k < 16; k++) begin
      tick();
      chk("R2", chain_out, s[15-k]);
    end

    // Clear in mid-stream
    par_hi = 8'hFF; par_lo = 8'hFF;
    load_n = 1'b0; tick(); load_n = 1'b1;
    for (int k = 0; k < 3; k++) tick();
    chk("R2", chain_out, 1'b1);
    #1 clr_n = 1'b0;
    #1 chk("R4", chain_out, 1'b0);
    load_n = 1'b0; en_n = 1'b0;
    tick();
    chk("R5", chain_out, 1'b0);
    load_n = 1'b1; ser_in = 1'b0;
    #1 clr_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tick();
      chk("R4", chain_out, 1'b0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule